// File: doc/BRIEF.md
# DMA Interrupt Coalescing Control Register

This block is the 32-bit control register of a DMA engine, together with the logic that decides when the engine interrupts its host. Software reads and writes it over a simple bus with an address, a write strobe, write data and registered read data. A second word at another offset holds three status flags: completion, delay and error. Software clears a flag by writing 1 to its bit.

Completion interrupts are coalesced in two ways. A countdown counter raises the completion flag only after a programmed number of completion events. A packet-idle timer raises the delay flag when no new end-of-packet pulse arrives for a programmed number of prescaled ticks.

A single interrupt line combines the three flags, each gated by its own enable. Some writes are rejected: a write of zero to the threshold field, a mode change while the engine is busy, and a delay enable while scatter-gather mode is off. A soft-reset bit stays set until the engine reports that the reset is done. At that point the whole register returns to its reset state.

Top module: `dma_irq_coalesce`

## Requirements
- R1: After reset the control word at offset 0x0 reads 0x0001_0002, the status word at offset 0x4 reads 0 and irq is 0. The control bits are: [31:24] delay count, [23:16] threshold, [14] error enable, [13] delay enable, [12] completion enable, [6] cyclic, [5] fixed-address write, [4] fixed-address read, [3] scatter-gather mode, [2] soft reset, [1] tail-pointer flag. Bits 15, 11:7 and 0 always read 0.
- R2: Bit 1 reads 1 when SG_PRESENT is 1 and 0 when it is 0. Writes to bit 1 have no effect.
- R3: A control write whose threshold field is 0x00 keeps the previous threshold. The other fields of that write still take effect.
- R4: With SG_PRESENT=1, the completion flag is set by the completion pulse that brings the countdown (loaded from the threshold) to zero, and the countdown then reloads. With SG_PRESENT=0, every completion pulse sets the flag.
- R5: A control write with a nonzero threshold reloads the countdown from the new value, which discards any partial count.
- R6: An end-of-packet pulse starts or restarts the delay timer. The delay flag is set on the Nth tick after it, where N is the delay count. Expiry stops the timer until the next end-of-packet pulse. A delay count of 0 never sets the flag, and with SG_PRESENT=0 the timer never sets the flag.
- R7: Bit 13 can be written to 1 only if bit 3 was already 1 before that write. Otherwise it stays 0.
- R8: Bit 3 changes only on a write made while eng_idle is 1. It is held at 0 when SG_PRESENT is 0.
- R9: irq is registered. One cycle after any flag is set whose enable bit is 1, irq is 1. It is 0 one cycle after no flag is enabled.
- R10: Writing 1 to bit 0 (completion), bit 1 (delay) or bit 2 (error) at offset 0x4 clears that flag. A set event in the same cycle wins over the clear.
- R11: Writing 1 to bit 2 sets soft reset and drives srst_req. The bit stays 1, even through writes of 0, until a srst_done pulse arrives. That pulse then returns every register and flag to its reset value. A srst_done pulse with no soft reset pending is ignored.
- R12: An error pulse sets the error flag whatever the error enable is.
- R13: reg_rdata shows the word at the address presented one cycle earlier. An unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Byte address of the register word |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| cmplt_evt | input | 1 | Completion event pulse |
| pkt_end | input | 1 | End-of-packet pulse |
| err_evt | input | 1 | Error event pulse |
| eng_idle | input | 1 | Engine idle status |
| dly_tick | input | 1 | Prescaled tick for the delay timer |
| srst_done | input | 1 | Soft reset completion pulse from the engine |
| srst_req | output | 1 | Soft reset request (bit 2) |
| sts_cmplt | output | 1 | Completion flag |
| sts_dly | output | 1 | Delay flag |
| sts_err | output | 1 | Error flag |
| irq | output | 1 | Combined interrupt |

## Verification
The bench counts completion pulses one short of the threshold and one exactly at it. A countdown that is off by one fires a pulse early or late. It also rewrites the threshold in the middle of a count: a design that keeps the old partial count fires too soon. The delay timer is restarted by a second end-of-packet pulse, left to run after expiry, and given a count of zero. A timer that ignores the restart, or that re-arms itself, raises a spurious delay flag.

The write-side rules are tested directly. The bench writes a zero threshold, sets the delay enable before scatter-gather mode, and changes the mode while the engine is busy; each of these writes must be rejected. It also drives a flag set and a write-1 clear in the same cycle, where a design that gives the clear priority loses an error. For soft reset, the bench writes 0 to the bit while the reset is pending and sends a stray done pulse. A design that drops the bit early, or that clears on an unrequested done pulse, shows the wrong control word.

// File: rtl/dmaic_pkg.sv
package dmaic_pkg;
  localparam int DATA_W = 32;
  localparam int FLD_W  = 8;

  // control word bit positions (software visible)
  localparam int B_DLY_LO = 24;
  localparam int B_THR_LO = 16;
  localparam int B_ERREN  = 14;
  localparam int B_DLYEN  = 13;
  localparam int B_CMPEN  = 12;
  localparam int B_CYC    = 6;
  localparam int B_FXW    = 5;
  localparam int B_FXR    = 4;
  localparam int B_SG     = 3;
  localparam int B_SRST   = 2;
  localparam int B_TAIL   = 1;

  // status word bit positions
  localparam int S_CMPLT = 0;
  localparam int S_DLY   = 1;
  localparam int S_ERR   = 2;

  typedef struct packed {
    logic [FLD_W-1:0] dly_val;
    logic [FLD_W-1:0] thr;
    logic             err_en;
    logic             dly_en;
    logic             cmplt_en;
    logic             cyc;
    logic             fxw;
    logic             fxr;
    logic             sg;
    logic             srst;
  } ctrl_t;

  localparam logic [FLD_W-1:0] THR_RST = 8'h01;
endpackage

// File: rtl/dmaic_ctrl_reg.sv
module dmaic_ctrl_reg
  import dmaic_pkg::*;
#(
  parameter int SG_PRESENT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wdata,
  input  logic              eng_idle,
  output ctrl_t             ctrl,
  output logic              thr_load,
  output logic [FLD_W-1:0]  thr_wval
);
  logic [FLD_W-1:0] wr_thr;
  logic             sg_ok;

  assign wr_thr   = wdata[B_THR_LO +: FLD_W];
  assign thr_wval = wr_thr;
  assign thr_load = wr_ctrl && (wr_thr != '0);
  assign sg_ok    = (SG_PRESENT != 0) && eng_idle;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ctrl.dly_val  <= '0;
      ctrl.thr      <= THR_RST;
      ctrl.err_en   <= 1'b0;
      ctrl.dly_en   <= 1'b0;
      ctrl.cmplt_en <= 1'b0;
      ctrl.cyc      <= 1'b0;
      ctrl.fxw      <= 1'b0;
      ctrl.fxr      <= 1'b0;
      ctrl.sg       <= 1'b0;
      ctrl.srst     <= 1'b0;
    end else if (wr_ctrl) begin
      ctrl.dly_val  <= wdata[B_DLY_LO +: FLD_W];
      if (wr_thr != '0) ctrl.thr <= wr_thr;
      ctrl.err_en   <= wdata[B_ERREN];
      ctrl.dly_en   <= wdata[B_DLYEN] & ctrl.sg;
      ctrl.cmplt_en <= wdata[B_CMPEN];
      ctrl.cyc      <= wdata[B_CYC];
      ctrl.fxw      <= wdata[B_FXW];
      ctrl.fxr      <= wdata[B_FXR];
      if (sg_ok) ctrl.sg <= wdata[B_SG];
      if (wdata[B_SRST]) ctrl.srst <= 1'b1;
    end
  end

  assert_thr_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
    ctrl.thr != '0);
  assert_dly_en_needs_sg_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl.dly_en) |-> $past(ctrl.sg));
  assert_sg_busy_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(eng_idle) && !$past(clr)) |-> $stable(ctrl.sg));
  assert_srst_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (ctrl.srst && !clr) |=> ctrl.srst);
endmodule

// File: rtl/dmaic_coalesce.sv
module dmaic_coalesce
  import dmaic_pkg::*;
#(
  parameter int SG_PRESENT = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [FLD_W-1:0] thr,
  input  logic             thr_load,
  input  logic [FLD_W-1:0] thr_wval,
  input  logic             evt,
  output logic             hit
);
  generate
    if (SG_PRESENT != 0) begin : g_count
      logic [FLD_W-1:0] cnt;

      assign hit = evt && !thr_load && (cnt == FLD_W'(1));

      always_ff @(posedge clk) begin
        if (rst || clr)   cnt <= THR_RST;
        else if (thr_load) cnt <= thr_wval;
        else if (evt)      cnt <= (cnt == FLD_W'(1)) ? thr : cnt - 1'b1;
      end

      assert_cnt_range_R4: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) && (cnt <= thr));
    end else begin : g_direct
      assign hit = evt;
    end
  endgenerate
endmodule

// File: rtl/dmaic_delay.sv
module dmaic_delay
  import dmaic_pkg::*;
#(
  parameter int SG_PRESENT = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [FLD_W-1:0] dly_val,
  input  logic             pkt_end,
  input  logic             tick,
  output logic             expire
);
  generate
    if (SG_PRESENT != 0) begin : g_timer
      logic             running;
      logic [FLD_W-1:0] cnt;

      assign expire = running && tick && !pkt_end && (dly_val != '0) &&
                      (cnt == dly_val - 1'b1);

      always_ff @(posedge clk) begin
        if (rst || clr) begin
          running <= 1'b0;
          cnt     <= '0;
        end else if (pkt_end) begin
          running <= 1'b1;
          cnt     <= '0;
        end else if (expire) begin
          running <= 1'b0;
          cnt     <= '0;
        end else if (running && tick && (dly_val != '0)) begin
          cnt <= cnt + 1'b1;
        end
      end
    end else begin : g_none
      assign expire = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/dmaic_irq.sv
module dmaic_irq
  import dmaic_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              set_cmplt,
  input  logic              set_dly,
  input  logic              set_err,
  input  logic              wr_stat,
  input  logic [DATA_W-1:0] wdata,
  input  logic              en_cmplt,
  input  logic              en_dly,
  input  logic              en_err,
  output logic [2:0]        flags,
  output logic              irq
);
  logic [2:0] set_v, w1c_v, en_v;

  assign set_v = {set_err, set_dly, set_cmplt};
  assign en_v  = {en_err, en_dly, en_cmplt};
  assign w1c_v = wr_stat ? {wdata[S_ERR], wdata[S_DLY], wdata[S_CMPLT]} : 3'b000;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= set_v | (flags & ~w1c_v);
      irq   <= |(flags & en_v);
    end
  end

  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(|(flags & en_v)));
  assert_err_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (set_err && !clr) |=> flags[S_ERR]);
endmodule

// File: rtl/dma_irq_coalesce.sv
module dma_irq_coalesce
  import dmaic_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int SG_PRESENT = 1,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'h0,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              cmplt_evt,
  input  logic              pkt_end,
  input  logic              err_evt,
  input  logic              eng_idle,
  input  logic              dly_tick,
  input  logic              srst_done,
  output logic              srst_req,
  output logic              sts_cmplt,
  output logic              sts_dly,
  output logic              sts_err,
  output logic              irq
);
  localparam logic TAIL_FLAG = (SG_PRESENT != 0);

  ctrl_t            ctrl;
  logic             clr, wr_ctrl, wr_stat, thr_load, hit, expire;
  logic [FLD_W-1:0] thr_wval;
  logic [2:0]       flags;
  logic [31:0]      ctrl_word, rd_next;

  assign wr_ctrl = reg_wr && (reg_addr == CTRL_OFS);
  assign wr_stat = reg_wr && (reg_addr == STAT_OFS);
  assign clr     = ctrl.srst && srst_done;

  dmaic_ctrl_reg #(.SG_PRESENT(SG_PRESENT)) u_ctrl (
    .clk(clk), .rst(rst), .clr(clr), .wr_ctrl(wr_ctrl), .wdata(reg_wdata),
    .eng_idle(eng_idle), .ctrl(ctrl), .thr_load(thr_load), .thr_wval(thr_wval)
  );

  dmaic_coalesce #(.SG_PRESENT(SG_PRESENT)) u_coal (
    .clk(clk), .rst(rst), .clr(clr), .thr(ctrl.thr), .thr_load(thr_load),
    .thr_wval(thr_wval), .evt(cmplt_evt), .hit(hit)
  );

  dmaic_delay #(.SG_PRESENT(SG_PRESENT)) u_dly (
    .clk(clk), .rst(rst), .clr(clr), .dly_val(ctrl.dly_val),
    .pkt_end(pkt_end), .tick(dly_tick), .expire(expire)
  );

  dmaic_irq u_irq (
    .clk(clk), .rst(rst), .clr(clr),
    .set_cmplt(hit), .set_dly(expire), .set_err(err_evt),
    .wr_stat(wr_stat), .wdata(reg_wdata),
    .en_cmplt(ctrl.cmplt_en), .en_dly(ctrl.dly_en), .en_err(ctrl.err_en),
    .flags(flags), .irq(irq)
  );

  always_comb begin
    ctrl_word = '0;
    ctrl_word[B_DLY_LO +: FLD_W] = ctrl.dly_val;
    ctrl_word[B_THR_LO +: FLD_W] = ctrl.thr;
    ctrl_word[B_ERREN] = ctrl.err_en;
    ctrl_word[B_DLYEN] = ctrl.dly_en;
    ctrl_word[B_CMPEN] = ctrl.cmplt_en;
    ctrl_word[B_CYC]   = ctrl.cyc;
    ctrl_word[B_FXW]   = ctrl.fxw;
    ctrl_word[B_FXR]   = ctrl.fxr;
    ctrl_word[B_SG]    = ctrl.sg;
    ctrl_word[B_SRST]  = ctrl.srst;
    ctrl_word[B_TAIL]  = TAIL_FLAG;
  end

  always_comb begin
    rd_next = '0;
    if (reg_addr == CTRL_OFS)      rd_next = ctrl_word;
    else if (reg_addr == STAT_OFS) rd_next[2:0] = flags;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end

  assign srst_req  = ctrl.srst;
  assign sts_cmplt = flags[S_CMPLT];
  assign sts_dly   = flags[S_DLY];
  assign sts_err   = flags[S_ERR];
endmodule

// File: tb/test_dma_irq_coalesce.sv
module test_dma_irq_coalesce;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_CTRL = 4'h0;
  localparam logic [3:0] A_STAT = 4'h4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata, rdata_ns;
  logic cmplt_evt = 0, pkt_end = 0, err_evt = 0, eng_idle = 1, dly_tick = 0, srst_done = 0;
  logic srst_req, sts_cmplt, sts_dly, sts_err, irq;
  logic ns_srst, ns_cmplt, ns_dly, ns_err, ns_irq;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_irq_coalesce i_dma_irq_coalesce (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata), .cmplt_evt(cmplt_evt), .pkt_end(pkt_end), .err_evt(err_evt),
    .eng_idle(eng_idle), .dly_tick(dly_tick), .srst_done(srst_done),
    .srst_req(srst_req), .sts_cmplt(sts_cmplt), .sts_dly(sts_dly), .sts_err(sts_err), .irq(irq)
  );

  dma_irq_coalesce #(.SG_PRESENT(0)) i_dma_irq_coalesce_nosg (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata_ns), .cmplt_evt(cmplt_evt), .pkt_end(pkt_end), .err_evt(err_evt),
    .eng_idle(eng_idle), .dly_tick(dly_tick), .srst_done(srst_done),
    .srst_req(ns_srst), .sts_cmplt(ns_cmplt), .sts_dly(ns_dly), .sts_err(ns_err), .irq(ns_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d, output logic [31:0] dns);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = rdata; dns = rdata_ns;
  endtask

  task automatic pulse_cmplt();
    @(negedge clk); cmplt_evt = 1'b1; @(negedge clk); cmplt_evt = 1'b0;
  endtask
  task automatic pulse_eop();
    @(negedge clk); pkt_end = 1'b1; @(negedge clk); pkt_end = 1'b0;
  endtask
  task automatic pulse_tick();
    @(negedge clk); dly_tick = 1'b1; @(negedge clk); dly_tick = 1'b0;
  endtask
  task automatic pulse_err();
    @(negedge clk); err_evt = 1'b1; @(negedge clk); err_evt = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d, dn;
    rd(A_CTRL, d, dn);
    chk("R1 ctrl reset", d, 32'h0001_0002);
    chk("R2 tail flag without sg", dn, 32'h0001_0000);
    rd(A_STAT, d, dn);
    chk("R1 status reset", d, 32'h0);
    chk("R1 irq reset", {31'b0, irq}, 32'h0);
    rd(4'h8, d, dn);
    chk("R13 unmapped reads zero", d, 32'h0);
  endtask

  task automatic t_reserved();
    logic [31:0] d, dn;
    wr(A_CTRL, 32'h0000_8F81);
    rd(A_CTRL, d, dn);
    chk("R1 R2 R3 reserved and tail ignore writes", d, 32'h0001_0002);
  endtask

  task automatic t_thresh();
    logic [31:0] d, dn;
    wr(A_CTRL, 32'h0003_1000);
    rd(A_CTRL, d, dn);
    chk("R13 ctrl readback", d, 32'h0003_1002);
    pulse_cmplt(); pulse_cmplt();
    chk("R4 no flag before threshold", {31'b0, sts_cmplt}, 32'h0);
    pulse_cmplt();
    chk("R4 flag at threshold", {31'b0, sts_cmplt}, 32'h1);
    @(negedge clk);
    chk("R9 irq follows enabled flag", {31'b0, irq}, 32'h1);
    wr(A_STAT, 32'h1);
    chk("R10 w1c clears completion", {31'b0, sts_cmplt}, 32'h0);
    @(negedge clk);
    chk("R9 irq drops", {31'b0, irq}, 32'h0);
    pulse_cmplt(); pulse_cmplt();
    chk("R4 reload no early flag", {31'b0, sts_cmplt}, 32'h0);
    pulse_cmplt();
    chk("R4 reload flag again", {31'b0, sts_cmplt}, 32'h1);
    wr(A_STAT, 32'h7);
  endtask

  task automatic t_zero_thr();
    logic [31:0] d, dn;
    wr(A_CTRL, 32'h0000_1000);
    rd(A_CTRL, d, dn);
    chk("R3 zero threshold ignored", d, 32'h0003_1002);
  endtask

  task automatic t_reload();
    pulse_cmplt(); pulse_cmplt();
    wr(A_CTRL, 32'h0003_1000);
    pulse_cmplt(); pulse_cmplt();
    chk("R5 rewrite discards partial count", {31'b0, sts_cmplt}, 32'h0);
    pulse_cmplt();
    chk("R5 flag after full reloaded count", {31'b0, sts_cmplt}, 32'h1);
    wr(A_STAT, 32'h7);
  endtask

  task automatic t_error();
    logic [31:0] d, dn;
    wr(A_CTRL, 32'h0000_0000);
    pulse_err();
    chk("R12 error flag while disabled", {31'b0, sts_err}, 32'h1);
    @(negedge clk);
    chk("R9 disabled flag gives no irq", {31'b0, irq}, 32'h0);
    wr(A_CTRL, 32'h0000_4000);
    @(negedge clk);
    chk("R9 enabling raises irq", {31'b0, irq}, 32'h1);
    @(negedge clk);
    reg_addr = A_STAT; reg_wdata = 32'h4; reg_wr = 1'b1; err_evt = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; err_evt = 1'b0;
    chk("R10 set wins over clear", {31'b0, sts_err}, 32'h1);
    wr(A_STAT, 32'h4);
    rd(A_STAT, d, dn);
    chk("R10 error cleared", d, 32'h0);
  endtask

  task automatic t_mode();
    logic [31:0] d, dn;
    wr(A_CTRL, 32'h0000_2000);
    rd(A_CTRL, d, dn);
    chk("R7 delay enable blocked without sg", d & 32'h2000, 32'h0);
    eng_idle = 1'b0;
    wr(A_CTRL, 32'h0000_0008);
    rd(A_CTRL, d, dn);
    chk("R8 mode write ignored when busy", d & 32'h8, 32'h0);
    eng_idle = 1'b1;
    wr(A_CTRL, 32'h0000_0008);
    wr(A_CTRL, 32'h0000_2008);
    rd(A_CTRL, d, dn);
    chk("R7 R8 delay enable after sg", d, 32'h0003_200A);
    chk("R7 R8 no sg instance keeps mode off", dn & 32'h200A, 32'h0);
  endtask

  task automatic t_delay();
    wr(A_CTRL, 32'h0400_2008);
    pulse_eop();
    for (int i = 0; i < 3; i++) pulse_tick();
    chk("R6 no flag before count", {31'b0, sts_dly}, 32'h0);
    pulse_tick();
    chk("R6 flag at count", {31'b0, sts_dly}, 32'h1);
    chk("R6 no timer without sg", {31'b0, ns_dly}, 32'h0);
    @(negedge clk);
    chk("R9 delay irq", {31'b0, irq}, 32'h1);
    wr(A_STAT, 32'h2);
    for (int i = 0; i < 6; i++) pulse_tick();
    chk("R6 stopped after expiry", {31'b0, sts_dly}, 32'h0);
    pulse_eop();
    pulse_tick(); pulse_tick();
    pulse_eop();
    for (int i = 0; i < 3; i++) pulse_tick();
    chk("R6 restart by new packet", {31'b0, sts_dly}, 32'h0);
    pulse_tick();
    chk("R6 flag after restart", {31'b0, sts_dly}, 32'h1);
    wr(A_STAT, 32'h2);
    wr(A_CTRL, 32'h0000_2008);
    pulse_eop();
    for (int i = 0; i < 20; i++) pulse_tick();
    chk("R6 zero count disables", {31'b0, sts_dly}, 32'h0);
  endtask

  task automatic t_nosg();
    wr(A_STAT, 32'h7);
    pulse_cmplt();
    chk("R4 every completion flags without sg", {31'b0, ns_cmplt}, 32'h1);
    chk("R4 coalesced instance waits", {31'b0, sts_cmplt}, 32'h0);
    wr(A_STAT, 32'h7);
  endtask

  task automatic t_srst();
    logic [31:0] d, dn;
    wr(A_CTRL, 32'h0005_1008);
    pulse_err();
    wr(A_CTRL, 32'h0005_100C);
    rd(A_CTRL, d, dn);
    chk("R11 soft reset bit set", d, 32'h0005_100E);
    chk("R11 request out", {31'b0, srst_req}, 32'h1);
    repeat (5) @(negedge clk);
    wr(A_CTRL, 32'h0005_1008);
    rd(A_CTRL, d, dn);
    chk("R11 bit held through write of 0", d, 32'h0005_100E);
    @(negedge clk); srst_done = 1'b1; @(negedge clk); srst_done = 1'b0;
    rd(A_CTRL, d, dn);
    chk("R11 ctrl back to reset", d, 32'h0001_0002);
    rd(A_STAT, d, dn);
    chk("R11 flags cleared", d, 32'h0);
    chk("R11 request dropped", {31'b0, srst_req}, 32'h0);
    wr(A_CTRL, 32'h0002_1000);
    @(negedge clk); srst_done = 1'b1; @(negedge clk); srst_done = 1'b0;
    rd(A_CTRL, d, dn);
    chk("R11 stray done ignored", d, 32'h0002_1002);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_reserved();
    t_thresh();
    t_zero_thr();
    t_reload();
    t_error();
    t_mode();
    t_delay();
    t_nosg();
    t_srst();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule